// File: doc/BRIEF.md
# PCI Configuration Access Bridge

This block gives a host processor a small register window through which it can run single-beat PCI configuration transactions. It reaches both downstream devices (remote path) and the bridge's own configuration header (local path). Software first loads a target address, then a command word that carries active-low byte-lane enables, and then either supplies write data or collects read data. Each access becomes exactly one request on a simple configuration-cycle port. The request is held steady until the target acknowledges it, reports an error, or the timeout expires.

Failures leave sticky status bits and a captured faulting address in two error logs. One log covers the PCI side and one covers the host side. Software clears each bit by writing a one to it. A failed read returns all ones. Software builds the address word itself. For type 0 it uses a one-hot device select at the slot position, the function in [10:8] and the dword offset with [1:0]=00. For type 1 it uses the bus in [23:16], the slot in [15:11], the function in [10:8], the offset in [7:2] and bit 0 set. The bridge passes this word through unchanged.

Top module: `pcb_bridge`

## Requirements
- R1: After reset, `cyc_req` and `busy` are 0, and every status, error-address and read-data register reads 0.
- R2: A write to offset 0x10 with command 0xA in bits [3:0] and a legal enable in bits [7:4] starts a remote read on the next cycle. During that cycle `cyc_req`=1, `cyc_local`=0, `cyc_addr` equals the register at 0x0C, `cyc_cmd`=0xA and `cyc_be_n` equals the enable.
- R3: A write to 0x10 with command 0xB only arms a remote write; no request appears. The next write to 0x14 starts the request with `cyc_cmd`=0xB, the armed enable, and `cyc_wdata` equal to the data written, which is already lane-aligned.
- R4: The local command word at 0x00 holds the dword offset in bits [7:2], a write flag in bit 16 and the enable in bits [23:20]. A local read starts when 0x00 is written. A local write starts when 0x04 is written after an armed 0x00. In both cases `cyc_local`=1, `cyc_addr`={offset,00} and `cyc_cmd` equals the write flag.
- R5: On `cyc_ack` the request drops on the next cycle. For a read, the returned dword is stored in 0x18 (remote) or 0x08 (local).
- R6: `cyc_err` on a remote cycle sets PCI status bit 0 (offset 0x1C) and copies `cyc_addr` to 0x20. A read that fails this way returns 0xFFFFFFFF from its read-data register.
- R7: A request with no response is ended after exactly TMO_CYCLES cycles. On a remote cycle this sets PCI status bit 1, and a read returns 0xFFFFFFFF.
- R8: The legal enables are 0x0, 0xE, 0xD, 0xB, 0x7, 0xC and 0x3. Any other enable, or a remote command that is neither 0xA nor 0xB, starts no cycle. The rejection sets PCI status bit 0 (remote) or host status bit 0 at 0x24 (local) and captures the address.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it set.
- R10: While `busy`=1, writes to offsets 0x00, 0x04, 0x0C, 0x10 and 0x14 are ignored.
- R11: An error or timeout on a local cycle sets host status bit 0, and 0x28 captures the local address. A local read that fails returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| busy | output | 1 | A configuration cycle is in flight |
| cyc_req | output | 1 | Configuration request, held until it ends |
| cyc_local | output | 1 | 1 = bridge's own header, 0 = downstream |
| cyc_addr | output | 32 | Cycle address |
| cyc_cmd | output | 4 | Cycle command |
| cyc_be_n | output | 4 | Active-low byte-lane enables |
| cyc_wdata | output | 32 | Lane-aligned write data |
| cyc_ack | input | 1 | Target completed the cycle |
| cyc_err | input | 1 | Target reported an error |
| cyc_rdata | input | 32 | Read data, valid with cyc_ack |

## Verification
A launching register write shows up on `cyc_req` and its fields one cycle after the write edge. A rejected write shows up in the status registers one cycle after the write edge. A response driven for one cycle clears `cyc_req` and updates the read-data, status and address registers at the following edge. With no response, the request stays high for exactly TMO_CYCLES cycles. The bench drives every input just after a falling edge and samples every output at the next falling edge. It counts timeouts edge by edge, so each check lands in the first cycle where the result is due, and the timeout checks look at the last cycle where the request must still be high and the first cycle where it must be low.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
   localparam logic [7:0] OFF_LCMD  = 8'h00;
   localparam logic [7:0] OFF_LWD   = 8'h04;
   localparam logic [7:0] OFF_LRD   = 8'h08;
   localparam logic [7:0] OFF_CADDR = 8'h0C;
   localparam logic [7:0] OFF_CCMD  = 8'h10;
   localparam logic [7:0] OFF_CWD   = 8'h14;
   localparam logic [7:0] OFF_CRD   = 8'h18;
   localparam logic [7:0] OFF_PST   = 8'h1C;
   localparam logic [7:0] OFF_PEA   = 8'h20;
   localparam logic [7:0] OFF_HST   = 8'h24;
   localparam logic [7:0] OFF_HEA   = 8'h28;

   localparam logic [3:0]  CMD_RD    = 4'hA;
   localparam logic [3:0]  CMD_WR    = 4'hB;
   localparam int          LWR_BIT   = 16;
   localparam logic [31:0] LCMD_MASK = 32'h00F1_00FC;

   typedef struct packed {
      logic        local_path;
      logic        write;
      logic [31:0] addr;
      logic [3:0]  cmd;
      logic [3:0]  be_n;
      logic [31:0] wdata;
   } launch_t;

   function automatic logic be_ok(input logic [3:0] b);
      case (b)
         4'h0, 4'hE, 4'hD, 4'hB, 4'h7, 4'hC, 4'h3: be_ok = 1'b1;
         default:                                  be_ok = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/pcb_decode.sv
module pcb_decode
   import pcb_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [31:0]   reg_wdata,
   input  logic          busy,
   output logic          launch_vld,
   output launch_t       launch,
   output logic          rej_remote,
   output logic          rej_local,
   output logic [31:0]   rej_addr,
   output logic [31:0]   cfg_addr_q,
   output logic [7:0]    ccmd_q,
   output logic [31:0]   lcmd_q
);
   logic        wr_ok;
   logic        hit_lcmd, hit_lwd, hit_caddr, hit_ccmd, hit_cwd;
   logic        c_armed, l_armed;
   logic [3:0]  c_code, c_be, l_be;
   logic        c_legal, l_legal, l_wr;
   logic [31:0] l_off;

   assign wr_ok     = reg_wr && !busy;
   assign hit_lcmd  = wr_ok && (reg_addr == AW'(OFF_LCMD));
   assign hit_lwd   = wr_ok && (reg_addr == AW'(OFF_LWD));
   assign hit_caddr = wr_ok && (reg_addr == AW'(OFF_CADDR));
   assign hit_ccmd  = wr_ok && (reg_addr == AW'(OFF_CCMD));
   assign hit_cwd   = wr_ok && (reg_addr == AW'(OFF_CWD));

   assign c_code  = reg_wdata[3:0];
   assign c_be    = reg_wdata[7:4];
   assign c_legal = be_ok(c_be) && (c_code == CMD_RD || c_code == CMD_WR);
   assign l_be    = reg_wdata[23:20];
   assign l_wr    = reg_wdata[LWR_BIT];
   assign l_legal = be_ok(l_be);
   assign l_off   = {24'b0, reg_wdata[7:2], 2'b00};

   always_comb begin
      launch_vld = 1'b0;
      launch     = '0;
      if (hit_ccmd && c_legal && c_code == CMD_RD) begin
         launch_vld      = 1'b1;
         launch.addr     = cfg_addr_q;
         launch.cmd      = CMD_RD;
         launch.be_n     = c_be;
      end else if (hit_cwd && c_armed) begin
         launch_vld      = 1'b1;
         launch.write    = 1'b1;
         launch.addr     = cfg_addr_q;
         launch.cmd      = CMD_WR;
         launch.be_n     = ccmd_q[7:4];
         launch.wdata    = reg_wdata;
      end else if (hit_lcmd && l_legal && !l_wr) begin
         launch_vld        = 1'b1;
         launch.local_path = 1'b1;
         launch.addr       = l_off;
         launch.be_n       = l_be;
      end else if (hit_lwd && l_armed) begin
         launch_vld        = 1'b1;
         launch.local_path = 1'b1;
         launch.write      = 1'b1;
         launch.addr       = {24'b0, lcmd_q[7:2], 2'b00};
         launch.cmd        = 4'h1;
         launch.be_n       = lcmd_q[23:20];
         launch.wdata      = reg_wdata;
      end
   end

   assign rej_remote = hit_ccmd && !c_legal;
   assign rej_local  = hit_lcmd && !l_legal;
   assign rej_addr   = rej_local ? l_off : cfg_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_addr_q <= '0;
         ccmd_q     <= '0;
         lcmd_q     <= '0;
         c_armed    <= 1'b0;
         l_armed    <= 1'b0;
      end else begin
         if (hit_caddr) cfg_addr_q <= reg_wdata;
         if (hit_ccmd) begin
            ccmd_q  <= reg_wdata[7:0];
            c_armed <= c_legal && (c_code == CMD_WR);
         end else if (hit_cwd) begin
            c_armed <= 1'b0;
         end
         if (hit_lcmd) begin
            lcmd_q  <= reg_wdata & LCMD_MASK;
            l_armed <= l_legal && l_wr;
         end else if (hit_lwd) begin
            l_armed <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pcb_seq.sv
module pcb_seq
   import pcb_pkg::*;
#(
   parameter int TMO_CYCLES = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        launch_vld,
   input  launch_t     launch,
   input  logic        cyc_ack,
   input  logic        cyc_err,
   input  logic [31:0] cyc_rdata,
   output logic        cyc_req,
   output launch_t     cur,
   output logic        done,
   output logic        done_err,
   output logic        done_tmo,
   output logic [31:0] lrd_q,
   output logic [31:0] crd_q
);
   localparam int CW = $clog2(TMO_CYCLES + 1);

   logic          req_q;
   logic [CW-1:0] cnt_q;
   logic          expire;
   logic [31:0]   rd_val;

   assign expire   = (cnt_q == CW'(TMO_CYCLES - 1));
   assign done     = req_q && (cyc_ack || cyc_err || expire);
   assign done_err = req_q && cyc_err;
   assign done_tmo = req_q && !cyc_ack && !cyc_err && expire;
   assign rd_val   = (done_err || done_tmo) ? 32'hFFFF_FFFF : cyc_rdata;
   assign cyc_req  = req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         cnt_q <= '0;
         cur   <= '0;
         lrd_q <= '0;
         crd_q <= '0;
      end else if (!req_q) begin
         if (launch_vld) begin
            req_q <= 1'b1;
            cnt_q <= '0;
            cur   <= launch;
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (done) begin
            req_q <= 1'b0;
            if (!cur.write) begin
               if (cur.local_path) lrd_q <= rd_val;
               else                crd_q <= rd_val;
            end
         end
      end
   end
endmodule

// File: rtl/pcb_errlog.sv
module pcb_errlog #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   input  logic [31:0]  addr_i,
   output logic [W-1:0] st_o,
   output logic [31:0]  addr_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        st_o[i] <= 1'b0;
         else if (set_i[i]) st_o[i] <= 1'b1;
         else if (clr_i[i]) st_o[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_o <= '0;
      else if (|set_i) addr_o <= addr_i;
   end
endmodule

// File: rtl/pcb_bridge.sv
module pcb_bridge
   import pcb_pkg::*;
#(
   parameter int AW         = 6,
   parameter int TMO_CYCLES = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          busy,
   output logic          cyc_req,
   output logic          cyc_local,
   output logic [31:0]   cyc_addr,
   output logic [3:0]    cyc_cmd,
   output logic [3:0]    cyc_be_n,
   output logic [31:0]   cyc_wdata,
   input  logic          cyc_ack,
   input  logic          cyc_err,
   input  logic [31:0]   cyc_rdata
);
   if (AW < 6 || AW > 8) begin : g_bad_aw
      $error("pcb_bridge: AW must lie in 6..8");
   end
   if (TMO_CYCLES < 2) begin : g_bad_tmo
      $error("pcb_bridge: TMO_CYCLES must be at least 2");
   end

   logic        launch_vld, rej_remote, rej_local;
   launch_t     launch, cur;
   logic [31:0] rej_addr, cfg_addr_q, lcmd_q, lrd_q, crd_q;
   logic [7:0]  ccmd_q;
   logic        done, done_err, done_tmo;
   logic [1:0]  pci_set, pci_clr, pci_st;
   logic [0:0]  host_set, host_clr, host_st;
   logic [31:0] pci_ea, host_ea, pci_ain, host_ain;

   pcb_decode #(.AW(AW)) i_decode (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .busy(busy), .launch_vld(launch_vld),
      .launch(launch), .rej_remote(rej_remote), .rej_local(rej_local),
      .rej_addr(rej_addr), .cfg_addr_q(cfg_addr_q), .ccmd_q(ccmd_q),
      .lcmd_q(lcmd_q)
   );

   pcb_seq #(.TMO_CYCLES(TMO_CYCLES)) i_seq (
      .clk(clk), .rst_n(rst_n), .launch_vld(launch_vld), .launch(launch),
      .cyc_ack(cyc_ack), .cyc_err(cyc_err), .cyc_rdata(cyc_rdata),
      .cyc_req(cyc_req), .cur(cur), .done(done), .done_err(done_err),
      .done_tmo(done_tmo), .lrd_q(lrd_q), .crd_q(crd_q)
   );

   assign busy      = cyc_req;
   assign cyc_local = cur.local_path;
   assign cyc_addr  = cur.addr;
   assign cyc_cmd   = cur.cmd;
   assign cyc_be_n  = cur.be_n;
   assign cyc_wdata = cur.wdata;

   assign pci_set[0]  = rej_remote || (done_err && !cur.local_path);
   assign pci_set[1]  = done_tmo && !cur.local_path;
   assign pci_ain     = rej_remote ? rej_addr : cur.addr;
   assign host_set[0] = rej_local || ((done_err || done_tmo) && cur.local_path);
   assign host_ain    = rej_local ? rej_addr : cur.addr;
   assign pci_clr     = (reg_wr && reg_addr == AW'(OFF_PST)) ? reg_wdata[1:0] : 2'b00;
   assign host_clr    = (reg_wr && reg_addr == AW'(OFF_HST)) ? reg_wdata[0:0] : 1'b0;

   pcb_errlog #(.W(2)) i_pci_log (
      .clk(clk), .rst_n(rst_n), .set_i(pci_set), .clr_i(pci_clr),
      .addr_i(pci_ain), .st_o(pci_st), .addr_o(pci_ea)
   );

   pcb_errlog #(.W(1)) i_host_log (
      .clk(clk), .rst_n(rst_n), .set_i(host_set), .clr_i(host_clr),
      .addr_i(host_ain), .st_o(host_st), .addr_o(host_ea)
   );

   always_comb begin
      reg_rdata = '0;
      case (8'(reg_addr))
         OFF_LCMD:  reg_rdata = lcmd_q;
         OFF_LRD:   reg_rdata = lrd_q;
         OFF_CADDR: reg_rdata = cfg_addr_q;
         OFF_CCMD:  reg_rdata = {24'b0, ccmd_q};
         OFF_CRD:   reg_rdata = crd_q;
         OFF_PST:   reg_rdata = {30'b0, pci_st};
         OFF_PEA:   reg_rdata = pci_ea;
         OFF_HST:   reg_rdata = {31'b0, host_st};
         OFF_HEA:   reg_rdata = host_ea;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pcb_bridge_chk.sv
module pcb_bridge_chk
   import pcb_pkg::*;
#(
   parameter int TMO = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cyc_req,
   input logic        cyc_local,
   input logic        cyc_ack,
   input logic        cyc_err,
   input logic [3:0]  cyc_cmd,
   input logic [3:0]  cyc_be_n,
   input logic [31:0] cyc_addr,
   input logic [1:0]  pci_st,
   input logic [0:0]  host_st
);
   localparam int RW = $clog2(TMO + 2);
   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= '0;
      else if (cyc_req) run_q <= run_q + 1'b1;
      else              run_q <= '0;
   end

   a_r2_remote_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_req && !cyc_local |-> (cyc_cmd == CMD_RD || cyc_cmd == CMD_WR));
   a_r8_legal_be: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_req |-> be_ok(cyc_be_n));
   a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_req && (cyc_ack || cyc_err) |=> !cyc_req);
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_req && $past(cyc_req) |-> $stable(cyc_addr) && $stable(cyc_be_n) && $stable(cyc_cmd));
   a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RW'(TMO));
   a_r6_pci_err: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_req && cyc_err && !cyc_local |=> pci_st[0]);
   a_r11_host_err: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_req && cyc_err && cyc_local |=> host_st[0]);
endmodule

bind pcb_bridge pcb_bridge_chk #(.TMO(TMO_CYCLES)) i_chk (
   .clk(clk), .rst_n(rst_n), .cyc_req(cyc_req), .cyc_local(cyc_local),
   .cyc_ack(cyc_ack), .cyc_err(cyc_err), .cyc_cmd(cyc_cmd),
   .cyc_be_n(cyc_be_n), .cyc_addr(cyc_addr), .pci_st(pci_st),
   .host_st(host_st)
);

// File: tb/test_pcb_bridge.sv
module test_pcb_bridge;
   localparam int TMO = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        busy, cyc_req, cyc_local;
   logic [31:0] cyc_addr, cyc_wdata;
   logic [3:0]  cyc_cmd, cyc_be_n;
   logic        cyc_ack = 1'b0;
   logic        cyc_err = 1'b0;
   logic [31:0] cyc_rdata = '0;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   pcb_bridge #(.AW(6), .TMO_CYCLES(TMO)) i_pcb_bridge (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
      .cyc_req(cyc_req), .cyc_local(cyc_local), .cyc_addr(cyc_addr),
      .cyc_cmd(cyc_cmd), .cyc_be_n(cyc_be_n), .cyc_wdata(cyc_wdata),
      .cyc_ack(cyc_ack), .cyc_err(cyc_err), .cyc_rdata(cyc_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic resp(input logic a, input logic e, input logic [31:0] d);
      cyc_ack = a; cyc_err = e; cyc_rdata = d;
      @(negedge clk);
      cyc_ack = 1'b0; cyc_err = 1'b0;
   endtask

   task automatic clear_status();
      wr(6'h1C, 32'h3);
      wr(6'h24, 32'h1);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 cyc_req", {31'b0, cyc_req}, 32'h0);
      chk("R1 busy", {31'b0, busy}, 32'h0);
      for (int k = 0; k < 6; k++) begin
         logic [5:0] offs [6] = '{6'h08, 6'h18, 6'h1C, 6'h20, 6'h24, 6'h28};
         rd(offs[k], v);
         chk("R1 register", v, 32'h0);
      end
   endtask

   task automatic t_remote_read();
      logic [31:0] v;
      wr(6'h0C, 32'h0000_2210);
      wr(6'h10, 32'h0000_000A);
      chk("R2 req", {31'b0, cyc_req}, 32'h1);
      chk("R2 local", {31'b0, cyc_local}, 32'h0);
      chk("R2 addr", cyc_addr, 32'h0000_2210);
      chk("R2 cmd", {28'b0, cyc_cmd}, 32'hA);
      chk("R2 be", {28'b0, cyc_be_n}, 32'h0);
      resp(1'b1, 1'b0, 32'h1234_5678);
      chk("R5 req drop", {31'b0, cyc_req}, 32'h0);
      rd(6'h18, v);
      chk("R5 remote rdata", v, 32'h1234_5678);
   endtask

   task automatic t_remote_write();
      wr(6'h0C, 32'h0005_1901);
      wr(6'h10, 32'h0000_00CB);
      chk("R3 armed no req", {31'b0, cyc_req}, 32'h0);
      wr(6'h14, 32'h0000_BEEF);
      chk("R3 req", {31'b0, cyc_req}, 32'h1);
      chk("R3 cmd", {28'b0, cyc_cmd}, 32'hB);
      chk("R3 be", {28'b0, cyc_be_n}, 32'hC);
      chk("R3 wdata", cyc_wdata, 32'h0000_BEEF);
      chk("R3 addr", cyc_addr, 32'h0005_1901);
      resp(1'b1, 1'b0, 32'h0);
      chk("R5 write done", {31'b0, cyc_req}, 32'h0);
   endtask

   task automatic t_local();
      logic [31:0] v;
      wr(6'h00, 32'h0031_0006);
      chk("R4 local write armed", {31'b0, cyc_req}, 32'h0);
      wr(6'h04, 32'hABCD_0000);
      chk("R4 local req", {31'b0, cyc_req}, 32'h1);
      chk("R4 local flag", {31'b0, cyc_local}, 32'h1);
      chk("R4 local addr", cyc_addr, 32'h0000_0004);
      chk("R4 local be", {28'b0, cyc_be_n}, 32'h3);
      chk("R4 local cmd wr", {28'b0, cyc_cmd}, 32'h1);
      chk("R4 local wdata", cyc_wdata, 32'hABCD_0000);
      resp(1'b1, 1'b0, 32'h0);
      wr(6'h00, 32'h00E0_0008);
      chk("R4 local read req", {31'b0, cyc_req}, 32'h1);
      chk("R4 local read cmd", {28'b0, cyc_cmd}, 32'h0);
      chk("R4 local read addr", cyc_addr, 32'h0000_0008);
      resp(1'b1, 1'b0, 32'hCAFE_F00D);
      rd(6'h08, v);
      chk("R5 local rdata", v, 32'hCAFE_F00D);
   endtask

   task automatic t_remote_err();
      logic [31:0] v;
      wr(6'h0C, 32'h0000_4300);
      wr(6'h10, 32'h0000_00DA);
      resp(1'b0, 1'b1, 32'h5555_5555);
      rd(6'h18, v);
      chk("R6 rdata all ones", v, 32'hFFFF_FFFF);
      rd(6'h1C, v);
      chk("R6 pci status", v, 32'h1);
      rd(6'h20, v);
      chk("R6 err addr", v, 32'h0000_4300);
      wr(6'h1C, 32'h0);
      rd(6'h1C, v);
      chk("R9 write zero keeps", v, 32'h1);
      wr(6'h1C, 32'h1);
      rd(6'h1C, v);
      chk("R9 write one clears", v, 32'h0);
   endtask

   task automatic t_timeout();
      logic [31:0] v;
      wr(6'h0C, 32'h0000_0804);
      wr(6'h10, 32'h0000_000A);
      repeat (TMO - 1) @(negedge clk);
      chk("R7 still pending", {31'b0, cyc_req}, 32'h1);
      @(negedge clk);
      chk("R7 ended", {31'b0, cyc_req}, 32'h0);
      rd(6'h1C, v);
      chk("R7 status bit1", v, 32'h2);
      rd(6'h18, v);
      chk("R7 rdata all ones", v, 32'hFFFF_FFFF);
      clear_status();
   endtask

   task automatic t_illegal();
      logic [31:0] v;
      wr(6'h0C, 32'h0000_1110);
      wr(6'h10, 32'h0000_005A);
      chk("R8 no req bad be", {31'b0, cyc_req}, 32'h0);
      rd(6'h1C, v);
      chk("R8 pci status", v, 32'h1);
      rd(6'h20, v);
      chk("R8 addr", v, 32'h0000_1110);
      clear_status();
      wr(6'h10, 32'h0000_0003);
      chk("R8 no req bad code", {31'b0, cyc_req}, 32'h0);
      rd(6'h1C, v);
      chk("R8 bad code status", v, 32'h1);
      clear_status();
      wr(6'h00, 32'h0090_0014);
      chk("R8 no local req", {31'b0, cyc_req}, 32'h0);
      rd(6'h24, v);
      chk("R8 host status", v, 32'h1);
      rd(6'h28, v);
      chk("R8 host addr", v, 32'h0000_0014);
      clear_status();
   endtask

   task automatic t_busy();
      logic [31:0] v;
      wr(6'h0C, 32'h0000_2000);
      wr(6'h10, 32'h0000_007A);
      wr(6'h0C, 32'h0000_9999);
      wr(6'h10, 32'h0000_0051);
      chk("R10 addr held", cyc_addr, 32'h0000_2000);
      rd(6'h1C, v);
      chk("R10 no reject while busy", v, 32'h0);
      resp(1'b1, 1'b0, 32'h0);
      rd(6'h0C, v);
      chk("R10 addr reg unchanged", v, 32'h0000_2000);
   endtask

   task automatic t_local_err();
      logic [31:0] v;
      wr(6'h00, 32'h0000_0010);
      resp(1'b0, 1'b1, 32'h0);
      rd(6'h24, v);
      chk("R11 host status", v, 32'h1);
      rd(6'h28, v);
      chk("R11 host addr", v, 32'h0000_0010);
      rd(6'h08, v);
      chk("R11 local rdata ones", v, 32'hFFFF_FFFF);
      rd(6'h1C, v);
      chk("R11 pci untouched", v, 32'h0);
      clear_status();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_remote_read();
      t_remote_write();
      t_local();
      t_remote_err();
      t_timeout();
      t_illegal();
      t_busy();
      t_local_err();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule